// File: doc/BRIEF.md
# Burst Memory Target Data-Phase Controller

This block is the control core of a target on a 32-bit multiplexed address/data bus. On the first clock with the frame strobe sampled low, it takes the address and command from the bus. If the command is a memory read or memory write and the address lies in a programmable power-of-two window, it claims the cycle. It then drives device-select, target-ready and stop, and enables its drivers. All bus strobes are active low.

During a burst the controller holds its own dword address counter. Reads get one turnaround clock before the target drives data. Writes can complete on the clock right after the address. A simple back end supplies read data through a request/valid handshake and takes write strobes carrying the address, data and byte enables. The back end can hold off any data phase with a wait input. When a burst reaches the last dword of the window, the target disconnects, so the master must start again with a fresh address phase.

Top module: `burst_tgt_ctl`

## Requirements
- R1: A transaction starts on a clock where `frame_n` is sampled low and was high on the previous sample. It is claimed when `cbe_n` carries 4'b0110 (memory read) or 4'b0111 (memory write) and `(ad_in >> cfg_size) == (cfg_base >> cfg_size)`. A claim drives `devsel_n` low and `ctl_oe` high from the next clock.
- R2: Any other command, or an address outside the window, leaves `devsel_n`, `trdy_n` and `stop_n` high, `ad_oe` low, and gives no write strobe.
- R3: `trdy_n` is never low while `devsel_n` is high.
- R4: For a read, the clock after the address clock is a turnaround clock, with `trdy_n` high and `ad_oe` low. Read data and `trdy_n` low appear no earlier than the second clock after the address.
- R5: For a write, `trdy_n` may go low on the first clock after the address. Each write transfer pulses `be_wr_strobe` in that clock, with `be_wr_data = ad_in`, `be_byte_en = ~cbe_n` and `be_addr` set to the phase address.
- R6: A word moves only on an edge where `irdy_n` and `trdy_n` are both low. Once `trdy_n` is low, it stays low until such an edge.
- R7: While `be_wait` is high, or `be_rd_valid` is low for a pending read fetch, the sampled edge does not make `trdy_n` low on the next clock.
- R8: The phase address starts at the dword-aligned start address and rises by 4 after each transfer. It appears on `be_addr`: the fetch address while `be_rd_req` is high, otherwise the current phase address.
- R9: A transfer with `frame_n` high ends the transaction. On the next clock, `devsel_n`, `trdy_n` and `stop_n` are high and `ctl_oe` and `ad_oe` are low. These are also the reset values.
- R10: The data phase at the last dword of the window asserts `stop_n` low together with `trdy_n`. After that transfer, `trdy_n` stays high and `stop_n` stays low until `frame_n` is sampled high, and then everything is released on the next clock. No word beyond the window is moved.
- R11: `ad_oe` is high only while the target is claimed. Once set for a read, it stays high until the transaction ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Frame strobe from master |
| irdy_n | input | 1 | Initiator ready |
| cbe_n | input | 4 | Command (address clock) / active-low byte enables (data clocks) |
| ad_in | input | 32 | Address/data lines as sampled |
| cfg_base | input | 32 | Window base address |
| cfg_size | input | 5 | Window size as log2 of bytes |
| devsel_n | output | 1 | Device select |
| trdy_n | output | 1 | Target ready |
| stop_n | output | 1 | Disconnect request |
| ctl_oe | output | 1 | Enable for the target's control strobes |
| ad_out | output | 32 | Read data to drive on the bus |
| ad_oe | output | 1 | Enable for address/data drivers |
| be_addr | output | 32 | Back-end address (fetch or phase address) |
| be_rd_req | output | 1 | Read fetch request |
| be_rd_valid | input | 1 | Read data valid |
| be_rd_data | input | 32 | Read data from back end |
| be_wr_strobe | output | 1 | Write transfer strobe |
| be_wr_data | output | 32 | Write data |
| be_byte_en | output | 4 | Active-high byte lanes of the write |
| be_wait | input | 1 | Back-end wait request |

## Verification
The disconnect at the window's last dword can fall on the same transfer as the master's own final data phase. In that case `stop_n`, `trdy_n` low and `frame_n` high are all present at one edge. The stimulus table provokes this with single-word and exactly-fitting bursts that start so that their last word is the window's last dword. These are judged by the count of words moved, by seeing stop on that transfer, and by full release on the very next clock without an extra wait for the frame strobe. Longer bursts that overrun the window cover the other order, where the frame strobe is still low when stop is seen.

// File: rtl/tgt_pkg.sv
`timescale 1ns/1ps
package tgt_pkg;
  localparam int ADDR_W = 32;
  localparam int LANES  = ADDR_W / 8;
  localparam int SIZE_W = $clog2(ADDR_W);
  localparam int STEP   = LANES;

  localparam logic [LANES-1:0] CMD_MEM_RD = 4'b0110;
  localparam logic [LANES-1:0] CMD_MEM_WR = 4'b0111;

  typedef enum logic [1:0] {PH_IDLE, PH_TURN, PH_DATA} phase_t;

  // address lies in the power-of-two window starting at base
  function automatic logic region_hit(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] base,
                                      input logic [SIZE_W-1:0] sz);
    return (a >> sz) == (base >> sz);
  endfunction

  // next dword would leave the window
  function automatic logic region_last(input logic [ADDR_W-1:0] a,
                                       input logic [SIZE_W-1:0] sz);
    logic [ADDR_W-1:0] nx;
    nx = a + ADDR_W'(STEP);
    return (nx >> sz) != (a >> sz);
  endfunction

  function automatic logic [ADDR_W-1:0] dword_align(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(STEP - 1);
  endfunction
endpackage

// File: rtl/tgt_claim_dec.sv
`timescale 1ns/1ps
module tgt_claim_dec import tgt_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              frame_n,
  input  logic [LANES-1:0]  cbe_n,
  input  logic [ADDR_W-1:0] ad_in,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] size,
  output logic              claim,
  output logic              claim_rd
);
  logic frame_q;
  logic start, cmd_rd, cmd_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= 1'b1;
    else        frame_q <= frame_n;
  end

  assign start    = idle && frame_q && !frame_n;
  assign cmd_rd   = (cbe_n == CMD_MEM_RD);
  assign cmd_wr   = (cbe_n == CMD_MEM_WR);
  assign claim    = start && (cmd_rd || cmd_wr) && region_hit(ad_in, base, size);
  assign claim_rd = cmd_rd;
endmodule

// File: rtl/tgt_burst_ctr.sv
`timescale 1ns/1ps
module tgt_burst_ctr import tgt_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr
);
  always_comb begin
    if (load)      nxt_addr = dword_align(load_addr);
    else if (step) nxt_addr = cur_addr + ADDR_W'(STEP);
    else           nxt_addr = cur_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_addr <= '0;
    else        cur_addr <= nxt_addr;
  end
endmodule

// File: rtl/tgt_phase_fsm.sv
`timescale 1ns/1ps
module tgt_phase_fsm import tgt_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              claim,
  input  logic              claim_rd,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              be_wait,
  input  logic              be_rd_valid,
  input  logic [ADDR_W-1:0] be_rd_data,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic [SIZE_W-1:0] size,
  output logic              idle,
  output logic              xfer,
  output logic              finish,
  output logic              need_word,
  output logic              rd_mode,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              stop_n,
  output logic              ctl_oe,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] ad_out
);
  phase_t ph;
  logic   hold, after_stop, more, rd_load, trdy_go, stop_go;

  assign idle       = (ph == PH_IDLE);
  assign xfer       = (ph == PH_DATA) && !irdy_n && !trdy_n;
  assign hold       = (ph == PH_DATA) && !trdy_n && irdy_n;
  assign after_stop = (ph == PH_DATA) && !stop_n && trdy_n;
  assign finish     = frame_n && (xfer || after_stop);
  assign more       = (ph == PH_DATA) && !finish && stop_n && (trdy_n || xfer);
  assign need_word  = (ph == PH_TURN) || (more && rd_mode);
  assign rd_load    = need_word && be_rd_valid && !be_wait;

  always_comb begin
    trdy_go = 1'b0;
    case (ph)
      PH_IDLE: trdy_go = claim && !claim_rd && !be_wait;
      PH_TURN: trdy_go = rd_load;
      PH_DATA: trdy_go = hold || (rd_mode ? rd_load : (more && !be_wait));
      default: trdy_go = 1'b0;
    endcase
  end

  assign stop_go = (!idle && !stop_n && !finish) ||
                   (trdy_go && region_last(nxt_addr, size));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      rd_mode  <= 1'b0;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      ctl_oe   <= 1'b0;
      ad_oe    <= 1'b0;
      ad_out   <= '0;
    end else begin
      trdy_n <= !trdy_go;
      stop_n <= !stop_go;
      if (rd_load) ad_out <= be_rd_data;
      case (ph)
        PH_IDLE: if (claim) begin
          ph       <= claim_rd ? PH_TURN : PH_DATA;
          rd_mode  <= claim_rd;
          devsel_n <= 1'b0;
          ctl_oe   <= 1'b1;
        end
        PH_TURN: begin
          ph    <= PH_DATA;
          ad_oe <= 1'b1;
        end
        PH_DATA: if (finish) begin
          ph       <= PH_IDLE;
          rd_mode  <= 1'b0;
          devsel_n <= 1'b1;
          ctl_oe   <= 1'b0;
          ad_oe    <= 1'b0;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R3: target ready only under device select
  a_r3_trdy_needs_devsel: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);
  // R4: read claim is followed by a turnaround clock
  a_r4_read_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && claim && claim_rd) |=> (trdy_n && !ad_oe && !devsel_n));
  // R6: target ready held until the master is ready too
  a_r6_trdy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && irdy_n) |=> !trdy_n);
  // R9: everything released the clock after the end
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (devsel_n && trdy_n && stop_n && !ctl_oe && !ad_oe));
  // R10: stop held while frame still low
  a_r10_stop_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !frame_n) |=> !stop_n);
  // R11: data drivers only inside a claimed transaction
  a_r11_ad_oe_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (ctl_oe && !devsel_n));
endmodule

// File: rtl/burst_tgt_ctl.sv
`timescale 1ns/1ps
module burst_tgt_ctl import tgt_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [LANES-1:0]  cbe_n,
  input  logic [ADDR_W-1:0] ad_in,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SIZE_W-1:0] cfg_size,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              stop_n,
  output logic              ctl_oe,
  output logic [ADDR_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] be_addr,
  output logic              be_rd_req,
  input  logic              be_rd_valid,
  input  logic [ADDR_W-1:0] be_rd_data,
  output logic              be_wr_strobe,
  output logic [ADDR_W-1:0] be_wr_data,
  output logic [LANES-1:0]  be_byte_en,
  input  logic              be_wait
);
  logic              claim, claim_rd, idle, xfer, finish, need_word, rd_mode;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;

  tgt_claim_dec u_dec (
    .clk(clk), .rst_n(rst_n), .idle(idle), .frame_n(frame_n), .cbe_n(cbe_n),
    .ad_in(ad_in), .base(cfg_base), .size(cfg_size),
    .claim(claim), .claim_rd(claim_rd));

  tgt_burst_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .load(claim), .load_addr(ad_in), .step(xfer),
    .cur_addr(cur_addr), .nxt_addr(nxt_addr));

  tgt_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .claim(claim), .claim_rd(claim_rd),
    .frame_n(frame_n), .irdy_n(irdy_n), .be_wait(be_wait),
    .be_rd_valid(be_rd_valid), .be_rd_data(be_rd_data), .nxt_addr(nxt_addr),
    .size(cfg_size), .idle(idle), .xfer(xfer), .finish(finish),
    .need_word(need_word), .rd_mode(rd_mode), .devsel_n(devsel_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe), .ad_oe(ad_oe),
    .ad_out(ad_out));

  assign be_addr      = need_word ? nxt_addr : cur_addr;
  assign be_rd_req    = need_word;
  assign be_wr_strobe = xfer && !rd_mode;
  assign be_wr_data   = ad_in;
  assign be_byte_en   = ~cbe_n;

  // R5: a write strobe only on a completed handshake
  a_r5_strobe_on_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    be_wr_strobe |-> (!irdy_n && !trdy_n && !devsel_n));
  // R8: the phase address moves only across a transfer
  a_r8_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !xfer && !finish) |=> $stable(cur_addr));
endmodule

// File: tb/sim_burst_tgt_ctl.sv
`timescale 1ns/1ps
module sim_burst_tgt_ctl;
  import tgt_pkg::*;

  localparam logic [31:0] BASE  = 32'h0001_0000;
  localparam int          WBYTE = 64;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic [7:0]  n;
    logic [3:0]  gap;
    logic [3:0]  bw;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{4'h6, 32'h0001_0000, 8'd4, 4'd0, 4'd0},
    '{4'h7, 32'h0001_0010, 8'd5, 4'd1, 4'd0},
    '{4'h6, 32'h0001_0020, 8'd3, 4'd0, 4'd1},
    '{4'h7, 32'h0001_0030, 8'd6, 4'd0, 4'd0},
    '{4'h6, 32'h0001_0038, 8'd5, 4'd1, 4'd0},
    '{4'h7, 32'h0001_003C, 8'd1, 4'd0, 4'd0},
    '{4'h6, 32'h0001_0040, 8'd2, 4'd0, 4'd0},
    '{4'h2, 32'h0001_0000, 8'd2, 4'd0, 4'd0},
    '{4'h7, 32'h0001_0000, 8'd8, 4'd2, 4'd1},
    '{4'h6, 32'h0001_0038, 8'd2, 4'd0, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n, irdy_n, be_rd_valid, be_wait;
  logic [3:0]  cbe_n;
  logic [31:0] ad_in, be_rd_data;
  logic        devsel_n, trdy_n, stop_n, ctl_oe, ad_oe, be_rd_req, be_wr_strobe;
  logic [31:0] ad_out, be_addr, be_wr_data;
  logic [3:0]  be_byte_en;
  int          checks = 0;
  int          fails  = 0;

  always #2 clk = ~clk;

  function automatic logic [31:0] rdfun(input logic [31:0] a);
    return a ^ 32'hC3A5_0F96;
  endfunction
  function automatic logic [31:0] wdat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction
  function automatic logic [3:0] lanes(input int d);
    return (d % 2 == 1) ? 4'b1111 : 4'b1001;
  endfunction

  assign be_rd_data = rdfun(be_addr);

  burst_tgt_ctl u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n),
    .ad_in(ad_in), .cfg_base(BASE), .cfg_size(5'd6), .devsel_n(devsel_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe), .ad_out(ad_out),
    .ad_oe(ad_oe), .be_addr(be_addr), .be_rd_req(be_rd_req),
    .be_rd_valid(be_rd_valid), .be_rd_data(be_rd_data),
    .be_wr_strobe(be_wr_strobe), .be_wr_data(be_wr_data),
    .be_byte_en(be_byte_en), .be_wait(be_wait));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic released(input string tag);
    chk(devsel_n && trdy_n && stop_n && !ctl_oe && !ad_oe, tag,
        {27'd0, devsel_n, trdy_n, stop_n, ctl_oe, ad_oe}, 32'h1C);
  endtask

  task automatic run_txn(input vec_t v);
    int  d = 0, t = 0, gapc, words = 0, strobes = 0, room, expw;
    bit  claimed = 0, saw_stop = 0, stopped = 0, done = 0, hit, wr;
    wr   = (v.cmd == 4'h7);
    hit  = (v.cmd == 4'h6 || wr) && v.addr >= BASE && v.addr < BASE + WBYTE;
    room = (BASE + WBYTE - v.addr) / 4;
    expw = hit ? ((int'(v.n) < room) ? int'(v.n) : room) : 0;
    gapc = v.gap;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; cbe_n = v.cmd; ad_in = v.addr; be_wait = 1'b0;
    while (!done && t < 80) begin
      @(negedge clk);
      t++;
      be_wait = (v.bw != 0) && (t % 3 == 1);
      if (stopped) begin
        frame_n = 1'b1; irdy_n = 1'b0;
      end else begin
        irdy_n  = (gapc > 0);
        frame_n = !irdy_n && (d == int'(v.n) - 1);
        cbe_n   = ~lanes(d);
        ad_in   = wr ? wdat(v.addr + 32'(4 * d)) : 32'h0;
      end
      #1;
      if (!devsel_n) claimed = 1;
      if (be_wr_strobe) strobes++;
      if (!trdy_n) chk(!devsel_n, "R3 trdy low without devsel", {31'd0, devsel_n}, 0);
      if (stopped) done = 1;
      else if (!irdy_n && !trdy_n) begin
        if (wr) begin
          chk(be_wr_strobe && be_addr == v.addr + 32'(4 * d), "R8 write phase address",
              be_addr, v.addr + 32'(4 * d));
          chk(be_wr_data == wdat(v.addr + 32'(4 * d)) && be_byte_en == lanes(d),
              "R5 write data/lanes", be_wr_data, wdat(v.addr + 32'(4 * d)));
        end else begin
          chk(ad_out == rdfun(v.addr + 32'(4 * d)), "R8 read word",
              ad_out, rdfun(v.addr + 32'(4 * d)));
          chk(ad_oe && ctl_oe, "R11 drivers on during read", {31'd0, ad_oe}, 1);
        end
        words++; d++; gapc = v.gap;
        if (!stop_n) begin saw_stop = 1; stopped = 1; end
        if (frame_n) done = 1;
      end else if (gapc > 0) gapc--;
      if (t > 4 && !claimed) done = 1;
    end
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b1; be_wait = 1'b0;
    #1;
    released("R9 release after end");
    if (hit) chk(claimed, "R1 claim", {31'd0, claimed}, 1);
    else     chk(!claimed, "R2 no claim", {31'd0, claimed}, 0);
    chk(words == expw, "R6 words moved", words, expw);
    chk(strobes == (wr ? expw : 0), "R2 write strobes", strobes, wr ? expw : 0);
    chk(saw_stop == (hit && int'(v.n) >= room), "R10 disconnect seen",
        {31'd0, saw_stop}, {31'd0, hit && int'(v.n) >= room});
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
    be_rd_valid = 1'b1; be_wait = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    released("R9 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_txn(VEC[i]);

    // R4 and R7: single read, fetch held off by rd_valid
    @(negedge clk);
    frame_n = 1'b0; cbe_n = 4'h6; ad_in = 32'h0001_0004; be_rd_valid = 1'b0;
    #1;
    chk(devsel_n, "R1 no devsel in address clock", {31'd0, devsel_n}, 1);
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'h0;
    #1;
    chk(!devsel_n && ctl_oe, "R1 devsel after claim", {31'd0, devsel_n}, 0);
    chk(trdy_n && !ad_oe, "R4 turnaround clock", {30'd0, trdy_n, ad_oe}, 32'h2);
    @(negedge clk);
    #1;
    chk(trdy_n, "R7 rd_valid low holds trdy", {31'd0, trdy_n}, 1);
    be_rd_valid = 1'b1;
    @(negedge clk);
    #1;
    chk(!trdy_n && ad_oe && stop_n, "R4 read data after turnaround",
        {29'd0, trdy_n, ad_oe, stop_n}, 32'h3);
    chk(ad_out == rdfun(32'h0001_0004), "R8 read word", ad_out, rdfun(32'h0001_0004));
    @(negedge clk);
    irdy_n = 1'b1;
    #1;
    released("R9 release after single read");

    // R5: write with no turnaround
    @(negedge clk);
    frame_n = 1'b0; cbe_n = 4'h7; ad_in = 32'h0001_0008;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; cbe_n = ~4'b0101; ad_in = 32'hDEAD_BEEF;
    #1;
    chk(!trdy_n && !devsel_n, "R5 write ready on first clock", {31'd0, trdy_n}, 0);
    chk(be_wr_strobe && be_byte_en == 4'b0101 && be_wr_data == 32'hDEAD_BEEF,
        "R5 write strobe", {28'd0, be_byte_en}, 32'h5);
    chk(be_addr == 32'h0001_0008, "R8 write address", be_addr, 32'h0001_0008);
    @(negedge clk);
    irdy_n = 1'b1;
    #1;
    released("R9 release after single write");

    // R7: back-end wait blocks a write phase
    @(negedge clk);
    frame_n = 1'b0; cbe_n = 4'h7; ad_in = 32'h0001_0000; be_wait = 1'b1;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'h0; be_wait = 1'b0;
    #1;
    chk(trdy_n, "R7 be_wait holds trdy", {31'd0, trdy_n}, 1);
    @(negedge clk);
    #1;
    chk(!trdy_n && be_wr_strobe, "R7 write proceeds after wait", {31'd0, trdy_n}, 0);
    @(negedge clk);
    irdy_n = 1'b1;
    #1;
    released("R9 release after waited write");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule